// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Port

This block is a serial peripheral port for a small 8-bit controller. It moves one character of 2 to 16 bits at a time. In master mode it generates the serial clock and the chip select itself. In slave mode it follows a clock and a select that arrive from outside. The character length, the direction role, the interrupt enable and the clock divisor come from a 14-bit format word. The host writes the format word whenever the port is idle.

Outgoing characters enter through a valid/ready transmit stream. `tx_ready` is high only while no character is in flight. A word is taken on a cycle in which both `tx_valid` and `tx_ready` are high, and `tx_valid` may wait with its data held for as long as ready stays low. The last received character sits in a one-word holding buffer, which is offered on a valid/ready receive stream. `rx_valid` marks a full buffer, and a cycle with `rx_valid` and `rx_ready` both high consumes it. A character that completes while the buffer is still full sets an overrun flag. An interrupt line reports a full buffer when interrupts are enabled.

The serial format is fixed. The clock idles low, the data lines change on the falling clock edge, and they are sampled on the rising edge.

Top module: `spi_port`

## Requirements
- R1: In master mode, a transmit handshake starts a transfer. `cs_n_o` goes low on the next cycle, and `tx_ready` stays low until the character is complete.
- R2: Transmit data is left-justified. Bit 15 of the accepted word goes out first on `mosi_o`, followed by the next lower bits, for as many bits as the character length. The lower bits of the word are never sent.
- R3: A received character is right-justified in `rx_data`, with its last received bit at bit 0. All bits above the character length read as zero.
- R4: In master mode the serial clock idles low. Its period is 2*(D+1) system clocks, where D is the divisor in format bits [13:6]; D = 0 gives half the system clock.
- R5: The character length is L+1 bits, where L is format bits [3:0]. L = 0 is treated as a 2-bit character. Each transfer has exactly that many rising clock edges.
- R6: In master mode `cs_n_o` returns high 2*(D+1) system clocks after the last falling edge of the serial clock.
- R7: When a character completes, `rx_valid` goes high and the character appears in `rx_data`. A receive handshake clears `rx_valid`.
- R8: If a character completes while the buffer is full and not being read, `rx_overrun` is set and the old `rx_data` is kept. A receive handshake clears `rx_overrun`. If a read and a completion fall in the same cycle, the new character is loaded, `rx_valid` stays high and no overrun is flagged.
- R9: `irq` equals `rx_valid` ANDed with format bit 5, the interrupt enable.
- R10: With format bit 4 cleared (slave mode), the character in the transmit register is loaded when `cs_n_i` falls. It is shifted out MSB first on `miso_o`, while `mosi_i` is sampled on each rising edge of `sclk_i`. The character completes on its last rising edge.
- R11: A format write while a character is in flight is ignored. The transfer in progress and the ones after it keep the old format.
- R12: After reset the format word is zero (slave mode, 2-bit length). `cs_n_o` is high, `sclk_o` is low, `tx_ready` is high, and `rx_valid`, `rx_overrun` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_wr | input | 1 | Format word write strobe |
| fmt_data | input | 14 | Format: [13:6] divisor, [5] irq enable, [4] master, [3:0] length code |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port can accept a transmit word |
| tx_data | input | 16 | Left-justified transmit word |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_ready | input | 1 | Host consumes the buffer |
| rx_data | output | 16 | Right-justified received character |
| rx_overrun | output | 1 | A character was lost while the buffer was full |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| cs_n_o | output | 1 | Chip select driven in master mode |
| cs_n_i | input | 1 | Chip select received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
Two events can land on the same clock edge: a host read of the holding buffer and the arrival of a newly finished character. The bench fills the buffer and leaves it unread. It then starts a second master transfer and waits for `cs_n_o` to rise. It asserts `rx_ready` for exactly the next cycle, which is the cycle in which the finished word reaches the buffer. The result is judged correct if the old word is visible before that edge, and if afterwards the new word is held with `rx_valid` high and `rx_overrun` low.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 4;
  localparam int NB_W   = LEN_W + 1;
  localparam int HC_W   = LEN_W + 2;
  localparam int FMT_W  = DIV_W + LEN_W + 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             irq_en;
    logic             master;
    logic [LEN_W-1:0] len_code;
  } fmt_t;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              master,
  input  logic [DIV_W-1:0]  div,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_word,
  output logic              busy,
  output logic              word_valid,
  output logic [DATA_W-1:0] word,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              miso_o,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic              miso_i
);
  // pin synchronisers: index 0 sclk, 1 cs_n, 2 mosi
  localparam logic [2:0] SYNC_RST = 3'b010;
  logic [2:0] pin_raw, pin_s;
  assign pin_raw = {mosi_i, cs_n_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
  end

  logic [NB_W-1:0]   nbits, bcnt, bcnt_n;
  logic [HC_W-1:0]   hc, hn, last_fall, end_hc;
  logic [DATA_W-1:0] sreg, txhold, mask;
  logic              m_run, s_act, rbit, sclk_p, cs_p, tick;
  logic              s_rise, s_fall, cs_fall, start;

  always_comb begin
    nbits = (len_code == '0) ? NB_W'(2) : {1'b0, len_code} + 1'b1;
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(nbits));
  end

  assign last_fall = {nbits, 1'b0};
  assign end_hc    = last_fall + HC_W'(2);
  assign hn        = hc + 1'b1;
  assign bcnt_n    = bcnt + 1'b1;
  assign s_rise    = pin_s[0] && !sclk_p;
  assign s_fall    = !pin_s[0] && sclk_p;
  assign cs_fall   = !pin_s[1] && cs_p;
  assign start     = load_tx && master;
  assign busy      = m_run || s_act;
  assign mosi_o    = sreg[DATA_W-1];
  assign miso_o    = sreg[DATA_W-1];

  spi_port_baud #(.W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(m_run), .div(div), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0; hc <= '0; sclk_o <= 1'b0; cs_n_o <= 1'b1;
      sreg <= '0; txhold <= '0; rbit <= 1'b0; s_act <= 1'b0; bcnt <= '0;
      word_valid <= 1'b0; word <= '0; sclk_p <= 1'b0; cs_p <= 1'b1;
    end else begin
      word_valid <= 1'b0;
      sclk_p     <= pin_s[0];
      cs_p       <= pin_s[1];
      if (load_tx) txhold <= tx_word;
      if (master) begin
        s_act <= 1'b0;
        if (start) begin
          m_run <= 1'b1; hc <= '0; cs_n_o <= 1'b0; sclk_o <= 1'b0;
          sreg  <= tx_word;
        end else if (m_run && tick) begin
          hc <= hn;
          if (hn == end_hc) begin
            m_run <= 1'b0; cs_n_o <= 1'b1;
            word_valid <= 1'b1; word <= sreg & mask;
          end else if (hn <= last_fall) begin
            if (hn[0]) begin
              sclk_o <= 1'b1; rbit <= miso_i;
            end else begin
              sclk_o <= 1'b0; sreg <= {sreg[DATA_W-2:0], rbit};
            end
          end
        end
      end else begin
        if (pin_s[1]) begin
          s_act <= 1'b0;
        end else if (cs_fall) begin
          s_act <= 1'b1; bcnt <= '0; sreg <= txhold;
        end else if (s_act) begin
          if (s_rise) begin
            rbit <= pin_s[2];
            bcnt <= bcnt_n;
            if (bcnt_n == nbits) begin
              word_valid <= 1'b1;
              word <= {sreg[DATA_W-2:0], pin_s[2]} & mask;
            end
          end else if (s_fall) begin
            sreg <= {sreg[DATA_W-2:0], rbit};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_port_rxbuf.sv
module spi_port_rxbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_valid,
  input  logic [W-1:0] word,
  input  logic         rd,
  input  logic         irq_en,
  output logic         full,
  output logic         ovr,
  output logic [W-1:0] data,
  output logic         irq
);
  logic pop;
  assign pop = rd && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0; ovr <= 1'b0; data <= '0;
    end else begin
      if (word_valid && (!full || pop)) begin
        data <= word; full <= 1'b1;
      end else if (pop) begin
        full <= 1'b0;
      end
      if (word_valid && full && !pop) ovr <= 1'b1;
      else if (pop)                   ovr <= 1'b0;
    end
  end

  assign irq = full && irq_en;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_wr,
  input  logic [FMT_W-1:0]  fmt_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun,
  output logic              irq,
  output logic              sclk_o,
  input  logic              sclk_i,
  output logic              cs_n_o,
  input  logic              cs_n_i,
  output logic              mosi_o,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              miso_i
);
  fmt_t              fmt_q;
  logic              busy, eng_word_valid, is_master;
  logic [DATA_W-1:0] eng_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fmt_q <= '0;
    else if (fmt_wr && !busy) fmt_q <= fmt_t'(fmt_data);
  end

  assign is_master = fmt_q.master;
  assign tx_ready  = !busy;

  spi_port_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .len_code(fmt_q.len_code), .master(fmt_q.master), .div(fmt_q.div),
    .load_tx(tx_valid && tx_ready), .tx_word(tx_data),
    .busy(busy), .word_valid(eng_word_valid), .word(eng_word),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_o(miso_o),
    .sclk_i(sclk_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i), .miso_i(miso_i));

  spi_port_rxbuf #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .word_valid(eng_word_valid), .word(eng_word),
    .rd(rx_ready), .irq_en(fmt_q.irq_en),
    .full(rx_valid), .ovr(rx_overrun), .data(rx_data), .irq(irq));
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        is_master,
  input logic        cs_n_o,
  input logic        sclk_o,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [15:0] rx_data,
  input logic        rx_overrun,
  input logic        irq,
  input logic        word_valid
);
  // R1
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && is_master) |=> (!cs_n_o && !tx_ready));

  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R7
  pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !word_valid) |=> !rx_valid);

  // R8
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && word_valid) |=> (rx_overrun && $stable(rx_data)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !irq);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .is_master(is_master), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_overrun(rx_overrun), .irq(irq), .word_valid(eng_word_valid));

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fmt_wr = 1'b0;
  logic [13:0] fmt_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid, rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        rx_overrun, irq;
  logic        sclk_o, cs_n_o, mosi_o, miso_o;
  logic        sclk_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;

  int n_checks = 0, n_fail = 0, cyc = 0;

  spi_port dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_wr(fmt_wr), .fmt_data(fmt_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .irq(irq),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .cs_n_o(cs_n_o), .cs_n_i(cs_n_i),
    .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  // bench-side peer for master mode
  logic [15:0] pat = '0, cap = '0;
  int plen = 2, idx = -1, rises = 0, t1 = 0, t2 = 0, t_fall = 0, t_cs = 0;

  always @(negedge cs_n_o) begin
    rises = 0; cap = '0; idx = plen - 1;
    miso_i = pat[idx]; idx--;
  end
  always @(posedge sclk_o) begin
    rises++; cap = {cap[14:0], mosi_o};
    if (rises == 1) t1 = cyc;
    if (rises == 2) t2 = cyc;
  end
  always @(negedge sclk_o) begin
    t_fall = cyc;
    if (idx >= 0) begin miso_i = pat[idx]; idx--; end
  end
  always @(posedge cs_n_o) t_cs = cyc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_fmt(input logic [3:0] code, input bit mst, input bit ie, input logic [7:0] dv);
    @(negedge clk); fmt_wr = 1'b1; fmt_data = {dv, ie, mst, code};
    @(negedge clk); fmt_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); tx_valid = 1'b1; tx_data = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge cs_n_o); repeat (3) @(negedge clk);
  endtask

  function automatic int len_of(input logic [3:0] code);
    return (code == 0) ? 2 : int'(code) + 1;
  endfunction

  // stimulus / expected table: length code, divisor, tx word, peer pattern, expected mosi bits, expected rx
  localparam int NV = 6;
  localparam logic [3:0]  V_LEN [NV] = '{4'd15, 4'd7, 4'd1, 4'd4, 4'd11, 4'd0};
  localparam logic [7:0]  V_DIV [NV] = '{8'd0, 8'd1, 8'd3, 8'd2, 8'd0, 8'd0};
  localparam logic [15:0] V_TX  [NV] = '{16'hA5C3, 16'hD2FF, 16'h8000, 16'h6800, 16'h1230, 16'h4000};
  localparam logic [15:0] V_PAT [NV] = '{16'h3C5A, 16'hFF81, 16'hFFFD, 16'hABCD, 16'hF0F0, 16'h0002};
  localparam logic [15:0] V_MOSI[NV] = '{16'hA5C3, 16'h00D2, 16'h0002, 16'h000D, 16'h0123, 16'h0001};
  localparam logic [15:0] V_RX  [NV] = '{16'h3C5A, 16'h0081, 16'h0001, 16'h000D, 16'h00F0, 16'h0002};

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cs_n_o == 1'b1, "R12 cs_n_o", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R12 sclk_o", sclk_o, 0);
    chk(rx_valid == 1'b0 && rx_overrun == 1'b0 && irq == 1'b0, "R12 flags",
        {rx_valid, rx_overrun, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b1, "R12 tx_ready", tx_ready, 1);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      write_fmt(V_LEN[i], 1'b1, 1'b1, V_DIV[i]);
      plen = len_of(V_LEN[i]);
      pat  = V_PAT[i];
      send(V_TX[i]);
      chk(cs_n_o == 1'b0 && tx_ready == 1'b0, "R1 busy", {cs_n_o, tx_ready}, 0);
      wait_done();
      chk(rises == plen, "R5 edges", rises, plen);
      chk((cap & ((32'h1 << plen) - 1)) == V_MOSI[i], "R2 mosi", cap, V_MOSI[i]);
      if (plen >= 2)
        chk(t2 - t1 == 2 * (int'(V_DIV[i]) + 1), "R4 period", t2 - t1, 2 * (int'(V_DIV[i]) + 1));
      chk(t_cs - t_fall == 2 * (int'(V_DIV[i]) + 1), "R6 cs delay", t_cs - t_fall, 2 * (int'(V_DIV[i]) + 1));
      chk(rx_valid == 1'b1, "R7 valid", rx_valid, 1);
      chk(rx_data == V_RX[i], "R3 rx data", rx_data, V_RX[i]);
      chk(irq == 1'b1, "R9 irq set", irq, 1);
      read_rx();
      chk(rx_valid == 1'b0 && irq == 1'b0, "R7 cleared", {rx_valid, irq}, 0);
    end

    // R8 overrun keeps old data; R9 irq disabled
    write_fmt(4'd7, 1'b1, 1'b0, 8'd0);
    plen = 8;
    pat = 16'h0011; send(16'h5500); wait_done();
    pat = 16'h0022; send(16'hAA00); wait_done();
    chk(rx_overrun == 1'b1, "R8 overrun set", rx_overrun, 1);
    chk(rx_data == 16'h0011, "R8 old kept", rx_data, 16'h0011);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    read_rx();
    chk(rx_overrun == 1'b0 && rx_valid == 1'b0, "R8 cleared", {rx_overrun, rx_valid}, 0);

    // R8 read coincides with completion
    pat = 16'h0033; send(16'h1100); wait_done();
    pat = 16'h0044; send(16'h2200);
    @(posedge cs_n_o);
    @(negedge clk);
    chk(rx_data == 16'h0033, "R8 old before edge", rx_data, 16'h0033);
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk(rx_valid == 1'b1 && rx_overrun == 1'b0, "R8 collide flags", {rx_valid, rx_overrun}, 2'b10);
    chk(rx_data == 16'h0044, "R8 collide data", rx_data, 16'h0044);
    read_rx();

    // R11 format write during transfer ignored
    write_fmt(4'd3, 1'b1, 1'b1, 8'd3);
    plen = 4; pat = 16'h0005;
    send(16'h9000);
    repeat (4) @(negedge clk);
    write_fmt(4'd15, 1'b1, 1'b1, 8'd0);
    wait_done();
    chk(rises == 4, "R11 length kept", rises, 4);
    send(16'h9000); wait_done();
    chk(rises == 4, "R11 later length", rises, 4);
    chk(t2 - t1 == 8, "R11 later period", t2 - t1, 8);
    read_rx();

    // R10 slave mode
    write_fmt(4'd6, 1'b0, 1'b1, 8'd0);
    send(16'hB400);
    begin
      logic [6:0] sbits = 7'h4B;
      logic [6:0] scap = '0;
      @(negedge clk); cs_n_i = 1'b0;
      repeat (8) @(negedge clk);
      chk(tx_ready == 1'b0, "R10 busy", tx_ready, 0);
      for (int b = 6; b >= 0; b--) begin
        mosi_i = sbits[b];
        repeat (8) @(negedge clk);
        scap = {scap[5:0], miso_o};
        sclk_i = 1'b1;
        repeat (8) @(negedge clk);
        sclk_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      cs_n_i = 1'b1;
      repeat (6) @(negedge clk);
      chk(scap == 7'h5A, "R10 miso", scap, 7'h5A);
      chk(rx_valid == 1'b1 && rx_data == 16'h004B, "R10 rx", rx_data, 16'h004B);
      chk(irq == 1'b1, "R10 irq", irq, 1);
    end
    read_rx();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule